// File: doc/BRIEF.md
# Masked Priority Interrupt Arbiter

This block collects a vector of interrupt request lines and decides which one, if any, is presented to the processor. Sources are grouped in pairs (more generally, in groups of a parameterised size), and each group shares one 4-bit programmable level held in a small register bank. Software writes that bank through a synchronous address/data/write-enable port. Every cycle the arbiter finds the pending source with the highest level, settles ties by source index, and compares the winning level with the 4-bit mask level taken from the processor status word.

A winner whose level is strictly above the mask is accepted. The block then raises its request to the processor, one cycle later, together with the accepted level and the winning source index, which serves as the vector number. An active-low acceptance pin goes low with the request. It stays low until the processor signals handler entry on the acknowledge input. It stays low through that acknowledge if, in the same cycle, a request of higher level than the one being serviced is accepted.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset every level register holds 0. A source whose group level is 0 is never accepted, whatever the mask.
- R2: A write with `wr_en_i` high stores `wr_data_i` into level register `wr_addr_i` at the clock edge. The new level governs arbitration from the next cycle on.
- R3: Source i takes its level from register i / SRC_PER_FIELD (integer division). With the defaults, sources 2k and 2k+1 share register k.
- R4: Among pending sources, the one with the highest level wins. Lower-level pending sources have no effect on the result.
- R5: When several pending sources have the same highest level, the lowest source index wins. This applies both to sources sharing one register and to sources in different registers.
- R6: If the winning level is less than or equal to `mask_i`, the request is not forwarded. In the next cycle `cpu_req_o` is 0 and `cpu_lvl_o` and `cpu_vec_o` are 0.
- R7: If the winning level is strictly greater than `mask_i`, then one clock later `cpu_req_o` is 1, `cpu_lvl_o` carries the level and `cpu_vec_o` carries the winning source index.
- R8: `req_out_n_o` is 1 after reset. It goes to 0 in the same cycle as `cpu_req_o` first rises after an acceptance.
- R9: When `ack_i` is sampled high and no pending request has a level above both `cpu_lvl_o` and `mask_i`, `req_out_n_o` returns to 1 in the next cycle.
- R10: When `ack_i` is sampled high while a request is accepted whose level exceeds the current `cpu_lvl_o`, `req_out_n_o` stays 0.
- R11: Without an acknowledge, `req_out_n_o` stays 0 once driven low, even after every request line is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Level-sensitive interrupt request lines |
| wr_en_i | input | 1 | Level register write enable |
| wr_addr_i | input | FA_W | Level register index |
| wr_data_i | input | LVL_W | Level to store |
| mask_i | input | LVL_W | Mask level from the processor status word |
| ack_i | input | 1 | Handler entry acknowledge from the processor |
| cpu_req_o | output | 1 | Accepted request to the processor |
| cpu_lvl_o | output | LVL_W | Level of the accepted request |
| cpu_vec_o | output | IDX_W | Source index of the accepted request |
| req_out_n_o | output | 1 | Active-low acceptance pin |

## Verification
The bench targets the comparison boundary: a winning level equal to the mask must be refused, and a level one above it must pass. A `>=` compare would let the first through. Ties are exercised both inside one shared register and across two registers with equal levels; a scan that favours the higher index, or uses `>=` while scanning, would return the wrong vector. The pin tests acknowledge once with only an equal-level source pending and once with a higher-level source arriving in the same cycle. A design that ignores the pending level on acknowledge, or that releases the pin when the request line drops, would show the pin high when it should be low.

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
  parameter int N_SRC         = 16,
  parameter int SRC_PER_FIELD = 2,
  parameter int LVL_W         = 4,
  localparam int N_FIELDS     = (N_SRC + SRC_PER_FIELD - 1) / SRC_PER_FIELD,
  localparam int FA_W         = (N_FIELDS > 1) ? $clog2(N_FIELDS) : 1,
  localparam int IDX_W        = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              wr_en_i,
  input  logic [FA_W-1:0]   wr_addr_i,
  input  logic [LVL_W-1:0]  wr_data_i,
  input  logic [LVL_W-1:0]  mask_i,
  input  logic              ack_i,
  output logic              cpu_req_o,
  output logic [LVL_W-1:0]  cpu_lvl_o,
  output logic [IDX_W-1:0]  cpu_vec_o,
  output logic              req_out_n_o
);

  logic [LVL_W-1:0] prio_q  [N_FIELDS];
  logic [LVL_W-1:0] src_lvl [N_SRC];
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;
  logic             accept;
  logic             pin_low_q;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[f] <= '0;
      else if (wr_en_i && wr_addr_i == FA_W'(f))
        prio_q[f] <= wr_data_i;
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_lvl[s] = req_i[s] ? prio_q[s / SRC_PER_FIELD] : '0;
  end

  // ascending scan with strict compare: lowest index keeps a tie
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_lvl[i] > best_lvl) begin
        best_lvl = src_lvl[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign accept = best_lvl > mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_req_o <= 1'b0;
      cpu_lvl_o <= '0;
      cpu_vec_o <= '0;
    end else begin
      cpu_req_o <= accept;
      cpu_lvl_o <= accept ? best_lvl : '0;
      cpu_vec_o <= accept ? best_idx : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pin_low_q <= 1'b0;
    else if (ack_i)
      pin_low_q <= accept && (best_lvl > cpu_lvl_o);
    else
      pin_low_q <= pin_low_q | accept;
  end

  assign req_out_n_o = ~pin_low_q;

endmodule

module prio_irq_arbiter_chk #(
  parameter int LVL_W = 4,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] mask_i,
  input logic             ack_i,
  input logic             cpu_req_o,
  input logic [LVL_W-1:0] cpu_lvl_o,
  input logic [IDX_W-1:0] cpu_vec_o,
  input logic             req_out_n_o
);

  // R1
  level_zero_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_o |-> cpu_lvl_o != '0);

  // R7
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_o |-> cpu_lvl_o > $past(mask_i));

  // R6
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req_o |-> (cpu_lvl_o == '0 && cpu_vec_o == '0));

  // R8
  pin_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req_o) |-> !req_out_n_o);

  // R11
  pin_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_out_n_o) && !$past(ack_i)) |-> !req_out_n_o);

endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .ack_i(ack_i),
  .cpu_req_o(cpu_req_o), .cpu_lvl_o(cpu_lvl_o), .cpu_vec_o(cpu_vec_o),
  .req_out_n_o(req_out_n_o)
);

// File: tb/tb_prio_irq_arbiter.sv
module tb_prio_irq_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [3:0]  wr_data_i = '0;
  logic [3:0]  mask_i = '0;
  logic        ack_i = 1'b0;
  logic        cpu_req_o;
  logic [3:0]  cpu_lvl_o;
  logic [3:0]  cpu_vec_o;
  logic        req_out_n_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .mask_i(mask_i), .ack_i(ack_i),
    .cpu_req_o(cpu_req_o), .cpu_lvl_o(cpu_lvl_o), .cpu_vec_o(cpu_vec_o),
    .req_out_n_o(req_out_n_o)
  );

  typedef struct packed {
    logic [15:0] req;
    logic [3:0]  mask;
    logic        ereq;
    logic [3:0]  elvl;
    logic [3:0]  evec;
  } vec_t;

  // group levels: 0:3 1:7 2:7 3:0 4:12 5:1 6:15 7:5
  localparam logic [3:0] LVLS [8] = '{4'd3, 4'd7, 4'd7, 4'd0, 4'd12, 4'd1, 4'd15, 4'd5};

  localparam vec_t TBL [14] = '{
    '{16'h0001, 4'd0,  1'b1, 4'd3,  4'd0},   // R7
    '{16'h0003, 4'd0,  1'b1, 4'd3,  4'd0},   // R5 shared group
    '{16'h0002, 4'd0,  1'b1, 4'd3,  4'd1},   // R3
    '{16'h0030, 4'd0,  1'b1, 4'd7,  4'd4},   // R3
    '{16'h0028, 4'd0,  1'b1, 4'd7,  4'd3},   // R5 across groups
    '{16'h00C0, 4'd0,  1'b0, 4'd0,  4'd0},   // R1
    '{16'h0301, 4'd0,  1'b1, 4'd12, 4'd8},   // R4
    '{16'h0301, 4'd12, 1'b0, 4'd0,  4'd0},   // R6 equal
    '{16'h0301, 4'd11, 1'b1, 4'd12, 4'd8},   // R7 one above
    '{16'hFFFF, 4'd0,  1'b1, 4'd15, 4'd12},  // R4
    '{16'hFFFF, 4'd15, 1'b0, 4'd0,  4'd0},   // R6
    '{16'h0C01, 4'd0,  1'b1, 4'd3,  4'd0},   // R4
    '{16'h0C00, 4'd1,  1'b0, 4'd0,  4'd0},   // R6
    '{16'h4400, 4'd0,  1'b1, 4'd5,  4'd14}   // R4
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 4'(d);
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R8 reset pin", req_out_n_o, 1);
    chk("R1 reset req", cpu_req_o, 0);
    req_i = 16'hFFFF;
    step();
    step();
    chk("R1 unprogrammed levels", cpu_req_o, 0);
    chk("R8 pin idle", req_out_n_o, 1);
    req_i = '0;

    for (int f = 0; f < 8; f++) wr(f, LVLS[f]);

    ack_i = 1'b1;
    foreach (TBL[k]) begin
      req_i = TBL[k].req;
      mask_i = TBL[k].mask;
      step();
      chk($sformatf("R4-7 vec%0d req", k), cpu_req_o, TBL[k].ereq);
      chk($sformatf("R4-7 vec%0d lvl", k), cpu_lvl_o, TBL[k].elvl);
      chk($sformatf("R4-7 vec%0d idx", k), cpu_vec_o, TBL[k].evec);
    end

    // R2 rewrite a level
    req_i = '0; mask_i = '0;
    wr(7, 0);
    req_i = 16'h8000;
    step();
    chk("R2 cleared level", cpu_req_o, 0);
    req_i = '0;
    wr(7, 9);
    req_i = 16'h8000;
    step();
    chk("R2 new level", cpu_lvl_o, 9);
    chk("R2 new vec", cpu_vec_o, 15);

    // release pin with nothing pending
    req_i = '0;
    step();
    step();
    chk("R9 release idle", req_out_n_o, 1);
    ack_i = 1'b0;

    // R8 then R11
    req_i = 16'h0001;
    step();
    chk("R8 req up", cpu_req_o, 1);
    chk("R8 pin low", req_out_n_o, 0);
    req_i = '0;
    repeat (3) step();
    chk("R11 pin held", req_out_n_o, 0);
    chk("R11 req gone", cpu_req_o, 0);

    // R9 plain release
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    chk("R9 released", req_out_n_o, 1);

    // R10 higher arrival at acknowledge
    req_i = 16'h0001;
    step();
    chk("R10 setup lvl", cpu_lvl_o, 3);
    req_i = 16'h0101; ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    chk("R10 pin stays low", req_out_n_o, 0);
    chk("R10 new level", cpu_lvl_o, 12);

    // R9 equal level pending does not hold the pin
    req_i = 16'h0001;
    step();
    chk("R9 lower pending lvl", cpu_lvl_o, 3);
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    chk("R9 equal pending releases", req_out_n_o, 1);

    done = 1'b1;
    finish_run();
  end

endmodule